// File: doc/BRIEF.md
# Serial Converter Read Master

This block is the host side of a link to a two-channel successive-approximation converter that talks over three wires: chip select, a serial clock and one shared data wire. A client hands it a request carrying a 2-bit channel/mode code. The block lowers chip select and derives the serial clock from the system clock. It sends a start marker followed by the two code bits, then lets go of the data wire so the converter can answer.

The converter replies with one settling bit that should read low. It then sends the sample most significant bit first, and then the same sample again least significant bit first, sharing the LSB. The block captures the whole reply, takes the result from the first copy and compares it with the mirrored second copy. It returns the byte with a one-cycle valid strobe and an error flag. Chip select then stays high for a full serial period before the next request is taken.

Top module: `adc_link_master`

## Requirements
- R1: After reset, csN is high, sclk is low, sdaOe is low, resValid is low and reqReady is high.
- R2: A request is taken only in a cycle where reqValid and reqReady are both high, and csN falls on the next clock edge. reqValid pulses while reqReady is low start nothing and do not change the code being sent.
- R3: The serial clock idles low and has a period of 2*HALF_DIV system clocks, which at the default of 100 and a 50 MHz clock gives 250 kHz. Each transaction has exactly 3 + 2*RES_BITS rising edges (19 by default).
- R4: The data wire carries 1 at the first rising edge, reqCode[1] (single/differential) at the second and reqCode[0] (odd/even) at the third. The host only changes its driven bit on falling serial-clock edges.
- R5: sdaOe is high at the three address rising edges. It drops at the falling edge after the third one and stays low through the rest of the transaction.
- R6: The bit sampled at the fourth rising edge is the settling bit and is not part of the result. resData holds the bits sampled at rising edges 5 to 12, with edge 5 as bit 7.
- R7: resErr is 1 when the settling bit reads 1, or when any bit k in 1..7 sampled in the LSB-first copy (edges 13 to 19 carry bits 1 to 7) differs from bit k of the first copy. resData still carries the MSB-first copy.
- R8: csN rises at the falling edge that follows the last rising edge. resValid is high for exactly one cycle right after that edge. reqReady returns 2*HALF_DIV cycles after resValid, with csN high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqCode | input | 2 | Channel/mode code: bit 1 single/differential, bit 0 odd/even |
| reqReady | output | 1 | High while idle and able to take a request |
| sclk | output | 1 | Serial clock to the converter |
| csN | output | 1 | Active-low chip select |
| sdaOut | output | 1 | Value driven onto the shared data wire |
| sdaOe | output | 1 | Drive enable for the shared data wire |
| sdaIn | input | 1 | Level seen on the shared data wire |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | RES_BITS | Converted sample, MSB-first copy |
| resErr | output | 1 | Settling bit high or copy mismatch |

## Verification
The assertions assume that rstN is held low through the first edges and that the converter never drives the wire while sdaOe is high, so the level sampled on sdaIn is always known. The bench's converter model enables its driver only on the third falling edge after a transaction opens, and releases it when chip select rises. Between those points the wire settles to a pulled-up high. Requests are always offered at falling system-clock edges, and the extra ones sent while the block is busy come only after chip select is already low.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_TAIL,
    ST_GAP
  } linkState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;     // latch code, clear capture register
    logic shiftTx;  // advance the outgoing address bit
    logic capture;  // shift one received bit in
    logic finish;   // latch result and error
  } linkStrobe_t;

endpackage

// File: rtl/adc_link_datapath.sv
module adc_link_datapath
  import adc_link_pkg::*;
#(
  parameter int HALF_DIV = 100,
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runClk,
  input  linkStrobe_t         strobe,
  input  logic [1:0]          reqCode,
  input  logic                sdaIn,
  output logic                sclk,
  output logic                riseTick,
  output logic                fallTick,
  output logic                sdaOut,
  output logic [RES_BITS-1:0] resData,
  output logic                resErr
);

  localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam int RX_W  = 2 * RES_BITS;

  logic [CNT_W-1:0] divCnt;
  logic             sclkReg;
  logic             divWrap;
  logic [2:0]       txReg;
  logic [RX_W-1:0]  rxReg;
  logic             copyMismatch;

  // serial clock divider: toggles every HALF_DIV system clocks
  assign divWrap  = (divCnt == CNT_W'(HALF_DIV - 1));
  assign riseTick = runClk && divWrap && !sclkReg;
  assign fallTick = runClk && divWrap && sclkReg;
  assign sclk     = sclkReg;

  always_ff @(posedge clk) begin
    if (!rstN || !runClk) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (divWrap) begin
      divCnt  <= '0;
      sclkReg <= ~sclkReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // outgoing address: start marker, then the two code bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (strobe.load) begin
      txReg <= {1'b1, reqCode};
    end else if (strobe.shiftTx) begin
      txReg <= {txReg[1:0], 1'b0};
    end
  end

  assign sdaOut = txReg[2];

  // incoming reply: settle bit, MSB-first copy, LSB-first tail
  always_ff @(posedge clk) begin
    if (!rstN || strobe.load) begin
      rxReg <= '0;
    end else if (strobe.capture) begin
      rxReg <= {rxReg[RX_W-2:0], sdaIn};
    end
  end

  // bit k of the first copy sits at RES_BITS-1+k, the mirrored one at RES_BITS-1-k
  always_comb begin
    copyMismatch = 1'b0;
    for (int k = 1; k < RES_BITS; k++) begin
      if (rxReg[RES_BITS-1+k] != rxReg[RES_BITS-1-k]) begin
        copyMismatch = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resErr  <= 1'b0;
    end else if (strobe.finish) begin
      resData <= rxReg[RX_W-2:RES_BITS-1];
      resErr  <= rxReg[RX_W-1] | copyMismatch;
    end
  end

  AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOut) |-> $past(fallTick || strobe.load)); // R4

  AST_TICK_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    riseTick |=> sclk); // R3

endmodule

// File: rtl/adc_link_control.sv
module adc_link_control
  import adc_link_pkg::*;
#(
  parameter int HALF_DIV = 100,
  parameter int RES_BITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        riseTick,
  input  logic        fallTick,
  output logic        runClk,
  output logic        csN,
  output logic        sdaOe,
  output logic        resValid,
  output linkStrobe_t strobe
);

  localparam int ADDR_BITS = 3;
  localparam int LAST_EDGE = ADDR_BITS + 2 * RES_BITS;
  localparam int EDGE_W    = $clog2(LAST_EDGE + 1);
  localparam int GAP_LEN   = 2 * HALF_DIV;
  localparam int GAP_W     = $clog2(GAP_LEN);

  linkState_t         state;
  logic [EDGE_W-1:0]  edgeCnt;
  logic [GAP_W-1:0]   gapCnt;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.shiftTx = (state == ST_XFER) && fallTick && (edgeCnt < EDGE_W'(ADDR_BITS));
    strobe.capture = (state == ST_XFER) && riseTick && (edgeCnt >= EDGE_W'(ADDR_BITS));
    strobe.finish  = (state == ST_TAIL) && fallTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      edgeCnt  <= '0;
      gapCnt   <= '0;
      runClk   <= 1'b0;
      csN      <= 1'b1;
      sdaOe    <= 1'b0;
      resValid <= 1'b0;
    end else begin
      resValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_XFER;
            edgeCnt <= '0;
            csN     <= 1'b0;
            sdaOe   <= 1'b1;
            runClk  <= 1'b1;
          end
        end
        ST_XFER: begin
          if (riseTick) begin
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == EDGE_W'(LAST_EDGE - 1)) begin
              state <= ST_TAIL;
            end
          end
          if (fallTick && (edgeCnt == EDGE_W'(ADDR_BITS))) begin
            sdaOe <= 1'b0;
          end
        end
        ST_TAIL: begin
          if (fallTick) begin
            state    <= ST_GAP;
            csN      <= 1'b1;
            runClk   <= 1'b0;
            resValid <= 1'b1;
            gapCnt   <= '0;
          end
        end
        default: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapCnt == GAP_W'(GAP_LEN - 1)) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(reqValid && reqReady)); // R2

  AST_WIRE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt > EDGE_W'(ADDR_BITS)) |-> !sdaOe); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R8

  AST_READY_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN); // R8

endmodule

// File: rtl/adc_link_master.sv
module adc_link_master
  import adc_link_pkg::*;
#(
  parameter int HALF_DIV = 100,
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqCode,
  output logic                reqReady,
  output logic                sclk,
  output logic                csN,
  output logic                sdaOut,
  output logic                sdaOe,
  input  logic                sdaIn,
  output logic                resValid,
  output logic [RES_BITS-1:0] resData,
  output logic                resErr
);

  linkStrobe_t strobe;
  logic        runClk;
  logic        riseTick;
  logic        fallTick;

  adc_link_control #(.HALF_DIV(HALF_DIV), .RES_BITS(RES_BITS)) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .riseTick (riseTick),
    .fallTick (fallTick),
    .runClk   (runClk),
    .csN      (csN),
    .sdaOe    (sdaOe),
    .resValid (resValid),
    .strobe   (strobe)
  );

  adc_link_datapath #(.HALF_DIV(HALF_DIV), .RES_BITS(RES_BITS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .runClk   (runClk),
    .strobe   (strobe),
    .reqCode  (reqCode),
    .sdaIn    (sdaIn),
    .sclk     (sclk),
    .riseTick (riseTick),
    .fallTick (fallTick),
    .sdaOut   (sdaOut),
    .resData  (resData),
    .resErr   (resErr)
  );

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN); // R3

  AST_VALID_CS_UP: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> csN); // R8

endmodule

// File: tb/tb_adc_link_master.sv
`timescale 1ns/1ps
module tb_adc_link_master;

  localparam int HALF   = 100;
  localparam int RES    = 8;
  localparam int EDGES  = 3 + 2 * RES;
  localparam int TCLK   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqCode = 2'b00;
  logic reqReady, sclk, csN, sdaOut, sdaOe, sdaIn, resValid, resErr;
  logic [RES-1:0] resData;

  always #(TCLK/2) clk = ~clk;

  adc_link_master #(.HALF_DIV(HALF), .RES_BITS(RES)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode),
    .reqReady(reqReady), .sclk(sclk), .csN(csN), .sdaOut(sdaOut),
    .sdaOe(sdaOe), .sdaIn(sdaIn), .resValid(resValid), .resData(resData),
    .resErr(resErr)
  );

  int compared = 0;
  int mismatched = 0;

  // converter model on the shared wire (pulled up when nobody drives)
  logic       devOe = 1'b0;
  logic       devBit = 1'b1;
  logic       busLine;
  logic [7:0] devValue = 8'h00;
  int         faultMode = 0;  // 0 clean, 1 settle bit high, 2 flip bit 4 of LSB-first copy
  int         riseCnt = 0, fallCnt = 0, csFalls = 0, driveViol = 0;
  logic [2:0] addrSeen = 3'b000;
  time        rise1T = 0, rise2T = 0, lastRiseT = 0, csRiseT = 0;

  assign busLine = sdaOe ? sdaOut : (devOe ? devBit : 1'b1);
  assign sdaIn   = busLine;

  function automatic logic replyBit(int f);
    int idx;
    idx = f - 3;
    if (idx == 0) return (faultMode == 1);
    if (idx <= 8) return devValue[8 - idx];
    return devValue[idx - 8] ^ ((faultMode == 2) && (idx - 8 == 4));
  endfunction

  always @(negedge csN) begin
    riseCnt = 0; fallCnt = 0; devOe = 1'b0; addrSeen = 3'b000;
    driveViol = 0; csFalls++;
  end

  always @(posedge csN) begin
    devOe = 1'b0;
    csRiseT = $time;
  end

  always @(posedge sclk) begin
    if (csN === 1'b0) begin
      riseCnt++;
      if (riseCnt == 1) rise1T = $time;
      if (riseCnt == 2) rise2T = $time;
      lastRiseT = $time;
      if (riseCnt <= 3) begin
        addrSeen = {addrSeen[1:0], busLine};
        if (sdaOe !== 1'b1) driveViol++;
      end else if (sdaOe !== 1'b0) begin
        driveViol++;
      end
    end
  end

  always @(negedge sclk) begin
    if (csN === 1'b0) begin
      fallCnt++;
      if (fallCnt >= 3 && fallCnt < EDGES) begin
        devOe  = 1'b1;
        devBit = replyBit(fallCnt);
      end else begin
        devOe = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN === 1'b1, "R1", "csN after reset", csN, 1);
    check(sclk === 1'b0, "R1", "sclk after reset", sclk, 0);
    check(sdaOe === 1'b0, "R1", "sdaOe after reset", sdaOe, 0);
    check(resValid === 1'b0, "R1", "resValid after reset", resValid, 0);
    check(reqReady === 1'b1, "R1", "reqReady after reset", reqReady, 1);
  endtask

  // one full read; pokeBusy sends extra requests while the block is busy
  task automatic run_read(input logic [1:0] code, input logic [7:0] val,
                          input int fault, input bit expErr, input bit pokeBusy);
    int n;
    int g;
    int fallsBefore;
    bit csLowInGap;
    devValue  = val;
    faultMode = fault;
    n = 0;
    while (reqReady !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    fallsBefore = csFalls;
    reqCode  = code;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(csN === 1'b0, "R2", "csN one cycle after accept", csN, 0);
    if (pokeBusy) begin
      repeat (700) @(negedge clk);
      reqCode  = ~code;
      reqValid = 1'b1;
      repeat (50) @(negedge clk);
      reqValid = 1'b0;
    end
    n = 0;
    while (resValid !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    check(resValid === 1'b1, "R8", "resValid seen", resValid, 1);
    check(resData === val, "R6", "resData", resData, val);
    check(resErr === expErr, "R7", "resErr", resErr, expErr);
    check(addrSeen === {1'b1, code}, "R4", "address bits on wire", addrSeen, {1'b1, code});
    check(driveViol == 0, "R5", "drive enable at rising edges", driveViol, 0);
    check(riseCnt == EDGES, "R3", "rising edges per transaction", riseCnt, EDGES);
    check(rise2T - rise1T == 2 * HALF * TCLK, "R3", "serial period ns",
          rise2T - rise1T, 2 * HALF * TCLK);
    check(csRiseT - lastRiseT == HALF * TCLK, "R8", "csN rise after last rise ns",
          csRiseT - lastRiseT, HALF * TCLK);
    @(negedge clk);
    check(resValid === 1'b0, "R8", "resValid one cycle only", resValid, 0);
    g = 1;
    csLowInGap = 1'b0;
    while (reqReady !== 1'b1 && g < 5000) begin
      if (csN !== 1'b1) csLowInGap = 1'b1;
      @(negedge clk);
      g++;
    end
    check(g == 2 * HALF, "R8", "cycles from resValid to reqReady", g, 2 * HALF);
    check(!csLowInGap, "R8", "csN high during gap", csLowInGap, 0);
    check(csFalls == fallsBefore + 1, "R2", "transactions started", csFalls - fallsBefore, 1);
    if (pokeBusy) begin
      repeat (3) @(negedge clk);
      check(csN === 1'b1, "R2", "busy request left no pending start", csN, 1);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    test_reset();
    run_read(2'b00, 8'hA5, 0, 1'b0, 1'b0);  // R6 clean, single-ended ch0
    run_read(2'b01, 8'h3C, 0, 1'b0, 1'b0);  // R4 odd/even bit set
    run_read(2'b10, 8'hFF, 0, 1'b0, 1'b0);  // R6 all ones
    run_read(2'b11, 8'h00, 0, 1'b0, 1'b0);  // R6 all zeros
    run_read(2'b01, 8'h5A, 0, 1'b0, 1'b1);  // R2 requests while busy
    run_read(2'b10, 8'h81, 1, 1'b1, 1'b0);  // R7 settle bit high
    run_read(2'b00, 8'hC3, 2, 1'b1, 1'b0);  // R7 copy mismatch
    run_read(2'b11, 8'h7E, 0, 1'b0, 1'b0);  // R7 error clears on clean read
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule